// File: doc/BRIEF.md
# Flash Status Toggle-Poll Controller

This block runs on the host side of a parallel flash device. Once software or a sequencer has issued an embedded program or erase command, it pulses `start_i`, and the controller takes over the wait. It reads the device status byte over and over from one fixed address, using a simple read port made of a request, an address, a data-valid strobe and a data byte. It decides when the embedded operation has finished by checking whether bit 6 of the status byte has stopped changing between successive reads.

Bit 5 of the status byte flags an internal time-limit failure. The status bits do not all settle in the same read, so a single sighting of bit 5 is never enough to declare failure. The controller first takes one more read to confirm. After bit 6 stops toggling, it takes one last read, and that byte is the final result. The outcome is given as a single-cycle pulse on one of three outputs: done, fail or timeout. A failure also raises a level that tells the surrounding logic the device needs a reset. The controller does not issue that reset itself.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy_o`, `rd_req_o`, `done_o`, `fail_o`, `timeout_o` and `reset_req_o` are 0 and `result_o` is 0.
- R2: The controller accepts `start_i` while idle and captures `addr_i` at that point. Every read of that polling run presents the captured address on `rd_addr_o`, without change.
- R3: A read request stays high until the cycle in which `rd_valid_i` is high. Each cycle with both `rd_req_o` and `rd_valid_i` high consumes exactly one status byte.
- R4: When bit 6 (mask 0x40) has the same value in two successive status reads, the controller performs exactly one further read. It then pulses `done_o` for one cycle, with that further byte on `result_o`.
- R5: If a read shows bit 6 changed and bit 5 (mask 0x20) set, the controller reads again. If the next read also shows bit 6 changed with bit 5 set, it pulses `fail_o`. `reset_req_o` then stays at 1 until the next accepted start.
- R6: If bit 5 was set on a toggling read and the following read shows bit 6 changed with bit 5 clear, the controller keeps polling. No fail is reported.
- R7: `max_polls_i` is captured at start. After a toggling read with bit 5 clear, if the number of reads completed in the run is at least that limit, the controller pulses `timeout_o` and leaves `reset_req_o` at 0.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The address, the read count and the outcome of the running poll are unaffected.
- R9: `done_o`, `fail_o` and `timeout_o` are never high together, and each lasts exactly one cycle. `busy_o` rises the cycle after an accepted start and falls the cycle after the outcome pulse.
- R10: The first read of a run is used only as a reference value, and its bit 5 is not examined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a polling run (ignored while busy) |
| addr_i | input | AW | Status address to poll |
| max_polls_i | input | CW | Read count limit for timeout |
| rd_req_o | output | 1 | Read request, held until data-valid |
| rd_addr_o | output | AW | Read address |
| rd_valid_i | input | 1 | Read data valid strobe |
| rd_data_i | input | 8 | Status byte returned by the device |
| busy_o | output | 1 | Polling run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | One-cycle confirmed-failure pulse |
| timeout_o | output | 1 | One-cycle timeout pulse |
| reset_req_o | output | 1 | Device needs a reset (held after failure) |
| result_o | output | 8 | Final status byte, valid with done_o |

## Verification
A wrong reference byte, a lost confirm flag or a miscounted read count shows up at the ports through a change in the number of status bytes consumed, and this happens within one or two reads of the fault. The outcome pulse can also arrive too soon or too late, or the wrong one of the three can fire. The bench feeds each run a scripted byte stream and compares, against a model of the rules, the outcome pulse, the result byte, `reset_req_o` and the exact number of bytes consumed. An unstable poll address is flagged on the very read where it changes.

// File: rtl/fpc_pkg.sv
// Shared types for the flash toggle-poll controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package fpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_FIRST,
        ST_READ_NEXT,
        ST_COMPARE,
        ST_CONFIRM,
        ST_DONE,
        ST_FAIL
    } poll_state_t;

    typedef enum logic [2:0] {
        VD_CONTINUE,
        VD_STABLE,
        VD_RECHECK,
        VD_FAILED,
        VD_TIMEOUT
    } verdict_t;

    localparam int TOGGLE_BIT = 6;
    localparam int ERROR_BIT  = 5;
endpackage

// File: rtl/fpc_read_port.sv
// Read-port front end: latches the poll address on load and holds the
// request while the FSM wants a read. Assumes the responder raises
// valid only while the request is high.
module fpc_read_port #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic          want_read,
    input  logic          rd_valid,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic          rd_done
);
    logic [AW-1:0] addr_q;

    // Capture the polling address once per run.
    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= addr_in;
    end

    // Request follows the FSM; a read finishes on the valid strobe.
    always_comb begin
        rd_req  = want_read;
        rd_addr = addr_q;
        rd_done = want_read && rd_valid;
    end
endmodule

// File: rtl/fpc_poll_counter.sv
// Counts completed reads of a run and flags when the latched limit is
// reached. Saturates at the top of its range.
module fpc_poll_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] limit_in,
    input  logic          inc,
    output logic          limit_hit
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit_q;

    // Clear on load, then count reads with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            limit_q <= '0;
        end else if (load) begin
            cnt_q   <= '0;
            limit_q <= limit_in;
        end else if (inc && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Limit reached when the read count meets or exceeds it.
    always_comb limit_hit = (cnt_q >= limit_q);
endmodule

// File: rtl/fpc_toggle_judge.sv
// Combinational decision on one pair of status reads: stable, recheck
// after a first error sighting, confirmed failure, timeout or continue.
module fpc_toggle_judge
    import fpc_pkg::*;
(
    input  logic [7:0] prev_byte,
    input  logic [7:0] cur_byte,
    input  logic       recheck_pending,
    input  logic       limit_hit,
    output verdict_t   verdict
);
    logic toggled;

    // Decide the next step from toggle and error bits.
    always_comb begin
        toggled = prev_byte[TOGGLE_BIT] ^ cur_byte[TOGGLE_BIT];
        if (!toggled)                  verdict = VD_STABLE;
        else if (cur_byte[ERROR_BIT])  verdict = recheck_pending ? VD_FAILED : VD_RECHECK;
        else if (limit_hit)            verdict = VD_TIMEOUT;
        else                           verdict = VD_CONTINUE;
    end
endmodule

// File: rtl/flash_poll_ctrl.sv
// Top of the flash toggle-poll controller. Sequences reads of a fixed
// status address, judges bit 6 / bit 5 and reports done, fail or
// timeout as one-cycle pulses. Assumes the device command was already
// issued before start_i.
module flash_poll_ctrl
    import fpc_pkg::*;
#(
    parameter int AW = 20,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] max_polls_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_valid_i,
    input  logic [7:0]    rd_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          fail_o,
    output logic          timeout_o,
    output logic          reset_req_o,
    output logic [7:0]    result_o
);
    poll_state_t state_q;
    verdict_t    verdict;
    logic [7:0]  prev_q, cur_q, result_q;
    logic        pend_q, tmo_q, rst_req_q;
    logic        load, want_read, rd_done, limit_hit;

    // Load on an idle start; read in the three read states.
    always_comb begin
        load      = (state_q == ST_IDLE) && start_i;
        want_read = (state_q == ST_READ_FIRST) || (state_q == ST_READ_NEXT) ||
                    (state_q == ST_CONFIRM);
    end

    fpc_read_port #(.AW(AW)) u_port (
        .clk(clk), .rst_n(rst_n), .load(load), .addr_in(addr_i),
        .want_read(want_read), .rd_valid(rd_valid_i),
        .rd_req(rd_req_o), .rd_addr(rd_addr_o), .rd_done(rd_done)
    );

    fpc_poll_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .limit_in(max_polls_i),
        .inc(rd_done), .limit_hit(limit_hit)
    );

    fpc_toggle_judge u_judge (
        .prev_byte(prev_q), .cur_byte(cur_q), .recheck_pending(pend_q),
        .limit_hit(limit_hit), .verdict(verdict)
    );

    // Polling sequence and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            prev_q    <= '0;
            cur_q     <= '0;
            result_q  <= '0;
            pend_q    <= 1'b0;
            tmo_q     <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q   <= ST_READ_FIRST;
                    pend_q    <= 1'b0;
                    rst_req_q <= 1'b0;
                end
                ST_READ_FIRST: if (rd_done) begin
                    prev_q  <= rd_data_i;
                    state_q <= ST_READ_NEXT;
                end
                ST_READ_NEXT: if (rd_done) begin
                    cur_q   <= rd_data_i;
                    state_q <= ST_COMPARE;
                end
                ST_COMPARE: begin
                    case (verdict)
                        VD_STABLE:  state_q <= ST_CONFIRM;
                        VD_RECHECK: begin
                            pend_q  <= 1'b1;
                            prev_q  <= cur_q;
                            state_q <= ST_READ_NEXT;
                        end
                        VD_FAILED: begin
                            tmo_q     <= 1'b0;
                            rst_req_q <= 1'b1;
                            state_q   <= ST_FAIL;
                        end
                        VD_TIMEOUT: begin
                            tmo_q   <= 1'b1;
                            state_q <= ST_FAIL;
                        end
                        default: begin
                            pend_q  <= 1'b0;
                            prev_q  <= cur_q;
                            state_q <= ST_READ_NEXT;
                        end
                    endcase
                end
                ST_CONFIRM: if (rd_done) begin
                    result_q <= rd_data_i;
                    state_q  <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outcome pulses and held outputs.
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_DONE);
        fail_o      = (state_q == ST_FAIL) && !tmo_q;
        timeout_o   = (state_q == ST_FAIL) && tmo_q;
        reset_req_o = rst_req_q;
        result_o    = result_q;
    end
endmodule

// File: rtl/flash_poll_ctrl_chk.sv
// Port-level property checker for flash_poll_ctrl, attached by bind.
module flash_poll_ctrl_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          rd_req_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          rd_valid_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          fail_o,
    input logic          timeout_o,
    input logic          reset_req_o
);
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_valid_i) |=> rd_req_o);

    a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, fail_o, timeout_o}));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o || timeout_o) |=> !busy_o);

    a_r5_fail_reset: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> reset_req_o);

    a_r7_tmo_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !reset_req_o);

    a_r3_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_o);

    a_r8_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !done_o && !fail_o && !timeout_o) |=> busy_o);
endmodule

bind flash_poll_ctrl flash_poll_ctrl_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i), .busy_o(busy_o),
    .done_o(done_o), .fail_o(fail_o), .timeout_o(timeout_o),
    .reset_req_o(reset_req_o)
);

// File: tb/test_flash_poll_ctrl.sv
module test_flash_poll_ctrl;
    localparam int AW = 20;
    localparam int CW = 16;
    localparam int SEQ_N = 80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [CW-1:0] max_polls_i = '0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_valid_i = 1'b0;
    logic [7:0]    rd_data_i = '0;
    logic          busy_o, done_o, fail_o, timeout_o, reset_req_o;
    logic [7:0]    result_o;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0]    seq [SEQ_N];
    int            idx = 0;
    int            wait_cnt = 0;
    logic [AW-1:0] exp_addr = '0;
    logic          addr_bad = 1'b0;

    always #5 clk = ~clk;

    flash_poll_ctrl #(.AW(AW), .CW(CW)) i_flash_poll_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .max_polls_i(max_polls_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
        .done_o(done_o), .fail_o(fail_o), .timeout_o(timeout_o),
        .reset_req_o(reset_req_o), .result_o(result_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Memory responder: one byte per valid strobe, random latency (R3).
    initial begin
        forever begin
            @(negedge clk);
            rd_valid_i = 1'b0;
            if (rd_req_o) begin
                if (rd_addr_o != exp_addr) addr_bad = 1'b1;
                if (wait_cnt == 0) begin
                    rd_valid_i = 1'b1;
                    rd_data_i  = seq[idx < SEQ_N ? idx : SEQ_N-1];
                    idx++;
                    wait_cnt = $urandom % 3;
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    // Model: kind 0 done, 1 fail, 2 timeout.
    task automatic model(input int mx, output int kind, output logic [7:0] res,
                         output int nreads);
        logic [7:0] prev, cur;
        bit pend = 0;
        int i = 1;
        prev = seq[0]; nreads = 1; kind = -1; res = '0;
        while (kind < 0 && i < SEQ_N - 1) begin
            cur = seq[i]; i++; nreads++;
            if (cur[6] == prev[6]) begin
                res = seq[i]; nreads++; kind = 0;
            end else if (cur[5]) begin
                if (pend) kind = 1;
                else begin pend = 1; prev = cur; end
            end else begin
                pend = 0;
                if (nreads >= mx) kind = 2; else prev = cur;
            end
        end
    endtask

    // Build a stream: k toggling reads, optional bit-5 pattern, then stable.
    task automatic build(input int k, input int mode);
        logic b6 = 1'($urandom);
        int j;
        for (int i = 0; i < SEQ_N; i++) begin
            seq[i] = 8'($urandom) & 8'hDF;
            seq[i][6] = (i < k) ? (b6 ^ 1'(i & 1)) : (b6 ^ 1'((k-1) & 1));
        end
        if (mode != 0 && k > 3) begin
            j = 1 + ($urandom % (k - 2));
            seq[j][5] = 1'b1;
            if (mode == 2) seq[j+1][5] = 1'b1;
        end
    endtask

    task automatic run(input int mx, input bit poke, input string tag);
        int kind, nreads, got, cyc;
        logic [7:0] res;
        logic [7:0] got_res;
        model(mx, kind, res, nreads);
        @(negedge clk);
        idx = 0; wait_cnt = $urandom % 3; addr_bad = 1'b0;
        exp_addr = AW'($urandom);
        addr_i = exp_addr; max_polls_i = CW'(mx); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; addr_i = ~exp_addr;
        check(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
        got = -1; cyc = 0; got_res = '0;
        while (got < 0 && cyc < 2000) begin
            @(negedge clk); cyc++;
            if (poke && cyc == 3) begin
                start_i = 1'b1; max_polls_i = '0;   // R8 ignored while busy
            end else start_i = 1'b0;
            if ((int'(done_o) + int'(fail_o) + int'(timeout_o)) > 1)
                check(0, "R9 exclusive pulses", 2, 1);
            if (done_o) begin got = 0; got_res = result_o; end
            else if (fail_o) got = 1;
            else if (timeout_o) got = 2;
        end
        start_i = 1'b0;
        check(got == kind, {tag, " outcome (R4/R5/R6/R7)"}, got, kind);
        check(idx == nreads, {tag, " reads consumed (R3/R4/R10)"}, idx, nreads);
        if (kind == 0) check(got_res == res, {tag, " R4 result byte"}, got_res, res);
        check(reset_req_o == (kind == 1), {tag, " R5/R7 reset request"}, reset_req_o, kind == 1);
        check(!addr_bad, {tag, " R2 address stable"}, addr_bad, 0);
        @(negedge clk);
        check(!busy_o && !done_o && !fail_o && !timeout_o,
              {tag, " R9 single-cycle pulse and idle"}, busy_o, 0);
        if (poke) check(idx == nreads, {tag, " R8 start ignored"}, idx, nreads);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < SEQ_N; i++) seq[i] = 8'h00;
        repeat (3) @(negedge clk);
        check(!busy_o && !rd_req_o && !done_o && !fail_o && !timeout_o && !reset_req_o &&
              result_o == 0, "R1 reset outputs", busy_o, 0);
        rd_n_release();
        check(!busy_o && !rd_req_o && result_o == 0, "R1 after reset", busy_o, 0);

        build(1, 0); run(50, 0, "immediate stable");
        build(6, 2); run(50, 0, "confirmed fail");
        build(8, 1); run(50, 0, "single error glitch R6");
        build(30, 0); run(0, 0, "limit zero timeout R7");
        build(30, 0); run(5, 0, "limit five timeout R7");
        build(9, 0); seq[0][5] = 1'b1; run(50, 0, "first read ignored R10");
        build(20, 0); run(10, 1, "start while busy R8");
        build(6, 2); run(50, 0, "fail then");
        build(3, 0); run(50, 0, "clears reset request R5");

        for (int t = 0; t < 40; t++) begin
            build(1 + ($urandom % 14), $urandom % 3);
            run(2 + ($urandom % 18), ($urandom % 4) == 0, "random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    task automatic rd_n_release();
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask
endmodule